// File: doc/BRIEF.md
# Early/Late Boundary Vote Generator

This block sits behind a receiver that samples a serial stream at twice the bit rate. One sample lands in the middle of each bit and one at each bit boundary. Each cycle the block takes a window of consecutive centre samples and the boundary samples between them. For every boundary it decides whether the sampling clock should move earlier, move later, or stay where it is.

The rule is a local comparison. A vote is cast only where the two centre samples around a boundary differ, which means a data transition happened there. When the boundary sample agrees with the centre sample before it, the edge arrived after the boundary point, so the sampling point should move later. When the boundary sample agrees with the centre sample after it, the sampling point should move earlier.

The votes for one window come out together, one register stage after the window is presented. The block does not weigh, count or filter the votes. A downstream loop filter does that and steers the phase interpolator.

Top module: `eld_phase_detector`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next outputs are `out_valid` = 0 and every vote = none (2'b00), whatever the inputs.
- R2: For boundary i, where `centre_smp[i]` equals `centre_smp[i+1]`, the vote is none (2'b00).
- R3: For boundary i, where `centre_smp[i]` differs from `centre_smp[i+1]` and `edge_smp[i]` equals `centre_smp[i]`, the vote is late (2'b10).
- R4: For boundary i, where `centre_smp[i]` differs from `centre_smp[i+1]` and `edge_smp[i]` equals `centre_smp[i+1]`, the vote is early (2'b01).
- R5: The code 2'b11 never appears in any vote field.
- R6: `out_valid` equals `in_valid` of the previous cycle. The votes shown with `out_valid` = 1 are those of the window presented in that previous cycle.
- R7: After a cycle with `in_valid` = 0, every vote is none, whatever the sample inputs held.
- R8: Vote i occupies `votes[2i+1:2i]` and depends only on `centre_smp[i]`, `centre_smp[i+1]` and `edge_smp[i]`. A transition at one boundary never produces a vote at another.
- R9: In a valid output, the number of non-none votes equals the number of adjacent unequal centre-sample pairs in the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample window valid strobe |
| centre_smp | input | NUM_BND+1 | Mid-bit samples, index 0 oldest |
| edge_smp | input | NUM_BND | Boundary samples; bit i lies between centre bits i and i+1 |
| out_valid | output | 1 | Registered valid, one cycle after `in_valid` |
| votes | output | 2*NUM_BND | Packed votes: 00 none, 01 early, 10 late |

## Verification
The bench builds the block with the default of eight boundaries per window. That covers both the lowest and the highest vote field, where an index slip would show up. Random windows at this width reach every mix of transition, no-transition, early and late across the window. Directed windows put a single transition at the first and at the last boundary. They also drive full alternation and idle cycles that carry live sample data.

// File: rtl/eld_pkg.sv
package eld_pkg;
    typedef enum logic [1:0] {
        VOTE_NONE  = 2'b00,
        VOTE_EARLY = 2'b01,
        VOTE_LATE  = 2'b10
    } vote_e;
endpackage

// File: rtl/eld_boundary_cmp.sv
module eld_boundary_cmp
    import eld_pkg::*;
(
    input  logic  prev_c,
    input  logic  bnd_s,
    input  logic  next_c,
    output vote_e vote
);
    always_comb begin
        if (prev_c == next_c) begin
            vote = VOTE_NONE;      // no transition, no information
        end else if (bnd_s == prev_c) begin
            vote = VOTE_LATE;      // edge came after the boundary point
        end else begin
            vote = VOTE_EARLY;     // edge came before the boundary point
        end
    end
endmodule

// File: rtl/eld_vote_array.sv
module eld_vote_array
    import eld_pkg::*;
#(
    parameter int NUM_BND = 8
) (
    input  logic [NUM_BND:0]     centre_smp,
    input  logic [NUM_BND-1:0]   edge_smp,
    output logic [2*NUM_BND-1:0] raw_votes
);
    for (genvar i = 0; i < NUM_BND; i++) begin : g_bnd
        vote_e v;
        eld_boundary_cmp cmp_i (
            .prev_c (centre_smp[i]),
            .bnd_s  (edge_smp[i]),
            .next_c (centre_smp[i+1]),
            .vote   (v)
        );
        assign raw_votes[2*i +: 2] = v;
    end
endmodule

// File: rtl/eld_out_reg.sv
module eld_out_reg #(
    parameter int NUM_BND = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [2*NUM_BND-1:0] raw_votes,
    output logic                 out_valid,
    output logic [2*NUM_BND-1:0] votes
);
    localparam int VW = 2 * NUM_BND;

    typedef struct packed {
        logic          valid;
        logic [VW-1:0] votes;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.votes = in_valid ? raw_votes : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign votes     = st_q.votes;
endmodule

// File: rtl/eld_phase_detector.sv
module eld_phase_detector #(
    parameter int NUM_BND = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [NUM_BND:0]     centre_smp,
    input  logic [NUM_BND-1:0]   edge_smp,
    output logic                 out_valid,
    output logic [2*NUM_BND-1:0] votes
);
    localparam int VW = 2 * NUM_BND;

    logic [VW-1:0] raw_votes;

    eld_vote_array #(.NUM_BND(NUM_BND)) arr_i (
        .centre_smp (centre_smp),
        .edge_smp   (edge_smp),
        .raw_votes  (raw_votes)
    );

    eld_out_reg #(.NUM_BND(NUM_BND)) reg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .raw_votes (raw_votes),
        .out_valid (out_valid),
        .votes     (votes)
    );
endmodule

// File: rtl/eld_phase_detector_chk.sv
module eld_phase_detector_chk #(
    parameter int NUM_BND = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [NUM_BND:0]     centre_smp,
    input logic [NUM_BND-1:0]   edge_smp,
    input logic                 out_valid,
    input logic [2*NUM_BND-1:0] votes
);
    function automatic bit has_code11(input logic [2*NUM_BND-1:0] v);
        for (int i = 0; i < NUM_BND; i++) if (v[2*i +: 2] == 2'b11) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int n_cast(input logic [2*NUM_BND-1:0] v);
        int n = 0;
        for (int i = 0; i < NUM_BND; i++) if (v[2*i +: 2] != 2'b00) n++;
        return n;
    endfunction

    function automatic int n_trans(input logic [NUM_BND:0] c);
        int n = 0;
        for (int i = 0; i < NUM_BND; i++) if (c[i] ^ c[i+1]) n++;
        return n;
    endfunction

    function automatic bit quiet_ok(input logic [2*NUM_BND-1:0] v,
                                    input logic [NUM_BND:0] c);
        for (int i = 0; i < NUM_BND; i++)
            if (c[i] == c[i+1] && v[2*i +: 2] != 2'b00) return 1'b0;
        return 1'b1;
    endfunction

    logic armed_q;
    logic rst_prev_q;
    always_ff @(posedge clk) begin
        armed_q    <= 1'b1;
        rst_prev_q <= rst_n;
    end

    // R1
    always @(posedge clk) begin
        if (armed_q && !rst_prev_q) begin
            reset_clear_chk: assert (out_valid == 1'b0 && votes == '0);
        end
    end

    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid));

    // R5
    no_code11_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !has_code11(votes));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> votes == '0);

    // R9
    vote_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid) |-> n_cast(votes) == n_trans($past(centre_smp)));

    // R2
    flat_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid) |-> quiet_ok(votes, $past(centre_smp)));
endmodule

bind eld_phase_detector eld_phase_detector_chk #(.NUM_BND(NUM_BND)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .centre_smp (centre_smp),
    .edge_smp   (edge_smp),
    .out_valid  (out_valid),
    .votes      (votes)
);

// File: tb/eld_phase_detector_tb.sv
module eld_phase_detector_tb_top;
    localparam int NB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [NB:0]   centre_smp = '0;
    logic [NB-1:0] edge_smp = '0;
    logic          out_valid;
    logic [2*NB-1:0] votes;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    eld_phase_detector #(.NUM_BND(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .centre_smp(centre_smp), .edge_smp(edge_smp),
        .out_valid(out_valid), .votes(votes)
    );

    function automatic logic [1:0] ref_vote(input logic p, input logic b, input logic n);
        if (p == n) return 2'b00;      // R2
        if (b == p) return 2'b10;      // R3
        return 2'b01;                  // R4
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at a falling edge, compare at the next falling edge
    task automatic apply(input logic v, input logic [NB:0] c, input logic [NB-1:0] e);
        in_valid   = v;
        centre_smp = c;
        edge_smp   = e;
        @(negedge clk);
        chk("R6", {31'd0, out_valid}, {31'd0, v});
        for (int i = 0; i < NB; i++) begin
            logic [1:0] ev;
            string r;
            ev = v ? ref_vote(c[i], e[i], c[i+1]) : 2'b00;
            if (!v) r = "R7";
            else if (c[i] == c[i+1]) r = "R2";
            else if (e[i] == c[i]) r = "R3";
            else r = "R4";
            chk(r, {30'd0, votes[2*i +: 2]}, {30'd0, ev});
            if (votes[2*i +: 2] == 2'b11) chk("R5", 32'd3, 32'd0);
        end
        if (v) begin
            int nc = 0, nt = 0;
            for (int i = 0; i < NB; i++) begin
                if (votes[2*i +: 2] != 2'b00) nc++;
                if (c[i] != c[i+1]) nt++;
            end
            chk("R9", nc, nt);
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [NB:0] c;
        logic [NB-1:0] e;
        void'($urandom(32'd1357));
        // R1: reset with live inputs
        @(negedge clk);
        in_valid = 1'b1; centre_smp = 9'b101010101; edge_smp = 8'hA5;
        @(negedge clk);
        @(negedge clk);
        chk("R1", {31'd0, out_valid}, 32'd0);
        chk("R1", {16'd0, votes}, 32'd0);
        rst_n = 1'b1;

        apply(1'b1, '0, 8'hFF);                       // R2 flat low, noisy edges
        apply(1'b1, '1, 8'h00);                       // R2 flat high
        c = 9'b010101010;
        apply(1'b1, c, c[NB-1:0]);                    // R3 all late
        apply(1'b1, c, c[NB:1]);                      // R4 all early
        apply(1'b1, 9'b000000001, 8'h01);             // R8 single at boundary 0, late
        apply(1'b1, 9'b100000000, 8'h80);             // R8 single at boundary 7, early
        apply(1'b0, c, 8'h5A);                        // R7 idle with live data
        apply(1'b1, 9'b011001100, 8'b00110011);       // mixed
        apply(1'b0, 9'b011001100, 8'b00110011);       // R7

        for (int k = 0; k < 3000; k++) begin
            c = NB'($urandom) | ((NB+1)'($urandom) & 9'h100);
            e = NB'($urandom);
            apply(($urandom % 8) != 0, c, e);
        end

        // R1: reset in the middle of traffic
        rst_n = 1'b0;
        in_valid = 1'b1; centre_smp = 9'h0F0; edge_smp = 8'h3C;
        @(negedge clk);
        chk("R1", {31'd0, out_valid}, 32'd0);
        chk("R1", {16'd0, votes}, 32'd0);
        rst_n = 1'b1;
        apply(1'b1, 9'h0F0, 8'h3C);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule